// File: doc/BRIEF.md
# Frame Sync Pulse Shaper

This block sits between a serial audio port that marks frames with a 50%-duty left/right word clock and a line-side modem codec that wants an active-low frame sync held low only while one 16-bit word moves. It runs from a master clock and halves it into the serial bit clock. It gives the codec an inverted copy of that bit clock, delayed by one master-clock register stage. It samples the word clock through a short synchronizer and acts on each rising edge of the sampled word clock at the next bit-clock rising step.

When a rising edge is seen, the sync output goes low for a set number of bit periods (16 by default) and then returns high. It then stays high until the word clock rises again. Falls and levels of the word clock between rising edges do nothing. A rising edge that arrives while the window is still open restarts the count, so the window is stretched and never split. With the default settings, a 256-bit frame at 8 kHz needs a 4.096 MHz master clock and gives a 2.048 MHz bit clock.

Top module: `fsync_shaper`

## Requirements
- R1: While the reset input is low, and for the first two master-clock edges after it rises, `fsync_n_o` is 1, `sclk_o` is 0 and `codec_clk_o` is 1.
- R2: Out of reset, `sclk_o` changes level every `HALF_DIV` master-clock cycles. It starts with a rise, so one bit period is 2*`HALF_DIV` cycles.
- R3: `codec_clk_o` in each master-clock cycle equals the inverse of `sclk_o` in the cycle before.
- R4: `lrck_i` passes through `SYNC_STAGES` master-clock flops. A 0-to-1 change of the sampled value, measured between consecutive bit-clock rising steps, drives `fsync_n_o` low at the same master-clock edge where `sclk_o` rises.
- R5: After a rising edge with no further edge, `fsync_n_o` stays low for exactly `WIN_BITS` bit periods and goes high together with a rise of `sclk_o`.
- R6: Once high, `fsync_n_o` stays high until the next sampled rising edge, whether `lrck_i` falls, stays low or stays high.
- R7: A rising edge detected while the window is open restarts the count, so the low time runs for `WIN_BITS` bit periods from the later edge.
- R8: The window counter saturates at `WIN_BITS`. A word clock held high for many times the window length never reopens the window.
- R9: If `lrck_i` is already high when reset ends, the bench treats its first sampled value as a rising edge and opens a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock, twice the bit rate by default |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lrck_i | input | 1 | Left/right word clock from the serial audio port |
| sclk_o | output | 1 | Serial bit clock made from the master clock |
| codec_clk_o | output | 1 | Inverted, one-stage delayed bit clock for the codec |
| fsync_n_o | output | 1 | Active-low frame sync, low for one data word |

## Verification
A change on `lrck_i` reaches `fsync_n_o` only after the synchronizer stages and the wait for the next bit-clock rising step. The sync register adds no further delay at that step, and `codec_clk_o` always trails `sclk_o` by one master-clock cycle. The bench drives inputs on falling edges and steps a behavioural model with integer counters and a sample queue once per rising edge. It compares all three outputs on the following falling edge, so every latency above is counted in cycles and not guessed. It also measures each clean low pulse directly against 2*`WIN_BITS`*`HALF_DIV` master-clock cycles.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int unsigned DEF_HALF_DIV    = 1;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_WIN_BITS    = 16;

  function automatic int unsigned width_for(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/fss_rst_sync.sv
module fss_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/fss_bit_clk.sv
module fss_bit_clk #(
  parameter int unsigned HALF_DIV = fss_pkg::DEF_HALF_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sclk_o,
  output logic codec_clk_o,
  output logic tick_o
);
  localparam int unsigned DW = fss_pkg::width_for(HALF_DIV - 1);
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          sclk_q, sclk_d;
  logic          codec_q, codec_d;
  logic          wrap;

  assign wrap   = (div_q == LAST);
  assign tick_o = wrap & ~sclk_q;

  always_comb begin
    div_d   = wrap ? '0 : div_q + DW'(1);
    sclk_d  = wrap ? ~sclk_q : sclk_q;
    codec_d = ~sclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      sclk_q  <= 1'b0;
      codec_q <= 1'b1;
    end else begin
      div_q   <= div_d;
      sclk_q  <= sclk_d;
      codec_q <= codec_d;
    end
  end

  assign sclk_o      = sclk_q;
  assign codec_clk_o = codec_q;

  // R2
  tick_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> sclk_q);
  // R3
  codec_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |=> $fell(codec_q));
endmodule

// File: rtl/fss_edge_det.sv
module fss_edge_det #(
  parameter int unsigned SYNC_STAGES = fss_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lrck_i,
  output logic rise_o
);
  logic samp;
  logic prev_q, prev_d;

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= 1'b0;
        else         s_q <= lrck_i;
      end
      assign samp = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] sh_q, sh_d;
      always_comb sh_d = {sh_q[SYNC_STAGES-2:0], lrck_i};
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
      end
      assign samp = sh_q[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    prev_d = tick_i ? samp : prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end

  assign rise_o = tick_i & samp & ~prev_q;

  // R4
  rise_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> prev_q);
endmodule

// File: rtl/fss_win_ctr.sv
module fss_win_ctr #(
  parameter int unsigned WIN_BITS = fss_pkg::DEF_WIN_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rise_i,
  output logic fsync_n_o
);
  localparam int unsigned CW = fss_pkg::width_for(WIN_BITS);
  localparam logic [CW-1:0] FULL = CW'(WIN_BITS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fs_q, fs_d;
  logic          full;

  assign full = (cnt_q == FULL);

  always_comb begin
    cnt_d = cnt_q;
    fs_d  = fs_q;
    if (tick_i) begin
      if (rise_i) begin
        cnt_d = CW'(1);
        fs_d  = 1'b0;
      end else if (full) begin
        fs_d  = 1'b1;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fs_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      fs_q  <= fs_d;
    end
  end

  assign fsync_n_o = fs_q;

  // R8
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (cnt_q == CW'(1)) && !fs_q);
  // R5
  close_at_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_q) |-> ($past(cnt_q) == FULL));
  // R6
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q && !rise_i) |=> fs_q);
endmodule

// File: rtl/fsync_shaper.sv
module fsync_shaper #(
  parameter int unsigned HALF_DIV    = fss_pkg::DEF_HALF_DIV,
  parameter int unsigned SYNC_STAGES = fss_pkg::DEF_SYNC_STAGES,
  parameter int unsigned WIN_BITS    = fss_pkg::DEF_WIN_BITS
) (
  input  logic mclk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  output logic sclk_o,
  output logic codec_clk_o,
  output logic fsync_n_o
);
  logic rst_n_int;
  logic tick;
  logic rise;

  fss_rst_sync u_rst (
    .clk_i       (mclk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  fss_bit_clk #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i       (mclk_i),
    .rst_ni      (rst_n_int),
    .sclk_o      (sclk_o),
    .codec_clk_o (codec_clk_o),
    .tick_o      (tick)
  );

  fss_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (mclk_i),
    .rst_ni (rst_n_int),
    .tick_i (tick),
    .lrck_i (lrck_i),
    .rise_o (rise)
  );

  fss_win_ctr #(.WIN_BITS(WIN_BITS)) u_win (
    .clk_i     (mclk_i),
    .rst_ni    (rst_n_int),
    .tick_i    (tick),
    .rise_i    (rise),
    .fsync_n_o (fsync_n_o)
  );

  // R4
  fall_on_sclk_rise_chk: assert property (@(posedge mclk_i) disable iff (!rst_n_int)
    $fell(fsync_n_o) |-> $rose(sclk_o));
  // R5
  close_on_sclk_rise_chk: assert property (@(posedge mclk_i) disable iff (!rst_n_int)
    $rose(fsync_n_o) |-> $rose(sclk_o));
endmodule

// File: tb/fsync_shaper_test.sv
module fsync_shaper_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 1;
  localparam int SYNC = 2;
  localparam int WIN  = 16;
  localparam int BITP = 2 * HALF;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0;
  logic sclk, codec, fs_n;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  fsync_shaper #(.HALF_DIV(HALF), .SYNC_STAGES(SYNC), .WIN_BITS(WIN)) uut (
    .mclk_i(mclk), .rst_ni(rst_n), .lrck_i(lrck),
    .sclk_o(sclk), .codec_clk_o(codec), .fsync_n_o(fs_n)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  // behavioural reference
  int  rstc = 0;
  bit  lq[$];
  int  m_div = 0, m_cnt = 0;
  bit  m_sclk = 0, m_codec = 1, m_prev = 0, m_fs = 1;

  task automatic model_reset();
    lq.delete();
    for (int i = 0; i < SYNC; i++) lq.push_back(1'b0);
    m_div = 0; m_cnt = 0; m_sclk = 0; m_codec = 1; m_prev = 0; m_fs = 1;
  endtask

  initial model_reset();

  always @(posedge mclk) begin
    if (!rst_n) begin
      rstc = 0; model_reset();
    end else if (rstc < 2) begin
      rstc++; model_reset();
    end else begin
      bit samp, wrap, tk, rs;
      samp = lq[0];
      wrap = (m_div == HALF - 1);
      tk   = wrap && !m_sclk;
      rs   = tk && samp && !m_prev;
      void'(lq.pop_front());
      lq.push_back(lrck);
      m_codec = !m_sclk;
      m_div   = wrap ? 0 : m_div + 1;
      if (wrap) m_sclk = !m_sclk;
      if (tk) begin
        m_prev = samp;
        if (rs) begin m_cnt = 1; m_fs = 0; end
        else if (m_cnt == WIN) m_fs = 1;
        else if (m_cnt > 0) m_cnt++;
      end
    end
  end

  task automatic cmp(input string req, input string nm, input bit act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: got %b expected %b", req, nm, $time, act, exp);
    end
  endtask

  int low_run = 0;
  always @(negedge mclk) begin
    if (!done) begin
      string rq;
      rq = (!rst_n || rstc < 2) ? "R1" : cur_req;
      cmp(rq, "fsync_n_o", fs_n, m_fs);
      cmp((rq == "R1") ? "R1" : "R2", "sclk_o", sclk, m_sclk);
      cmp((rq == "R1") ? "R1" : "R3", "codec_clk_o", codec, m_codec);
      if (fs_n === 1'b0) low_run++;
      else begin
        if (low_run > 0 && cur_req == "R5") begin
          n_cmp++;
          if (low_run != WIN * BITP) begin
            n_bad++;
            $display("FAIL R5 low width: got %0d expected %0d", low_run, WIN * BITP);
          end
        end
        low_run = 0;
      end
    end
  end

  task automatic bits(input bit v, input int n);
    lrck = v;
    repeat (n * BITP) @(negedge mclk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state with word clock low
    @(negedge mclk); @(negedge mclk); @(negedge mclk);
    rst_n = 1'b1;
    bits(0, 10);
    // R4, R5: regular 256-bit frames, 50% duty
    cur_req = "R5";
    for (int f = 0; f < 4; f++) begin bits(1, 128); bits(0, 128); end
    // R6: word clock falls inside window, then toggles low-only
    cur_req = "R6";
    bits(1, 4); bits(0, 60);
    bits(1, 30); bits(0, 2); bits(0, 30);
    // R8: held high far beyond the window
    cur_req = "R8";
    bits(1, 300); bits(0, 20);
    // R7: second rise while window open
    cur_req = "R7";
    bits(1, 3); bits(0, 5); bits(1, 6); bits(0, 40);
    bits(1, 14); bits(0, 1); bits(1, 40); bits(0, 20);
    // R4: short pulses of one bit each, spaced
    cur_req = "R4";
    for (int k = 0; k < 5; k++) begin bits(1, 1); bits(0, 25); end
    // R9: reset released with word clock high
    cur_req = "R1";
    @(negedge mclk); rst_n = 1'b0;
    lrck = 1'b1;
    repeat (4) @(negedge mclk);
    rst_n = 1'b1;
    repeat (4) @(negedge mclk);
    cur_req = "R9";
    bits(1, 40); bits(0, 20);
    finish_run();
  end
endmodule